// File: doc/BRIEF.md
# Triangle Duty-Cycle Sweep Generator

This block produces a duty-cycle value that climbs from 0 to 100 and falls back to 0, over and over, in steps of 2. An internal prescaler sets the pace. It emits a one-clock step pulse every `PRESCALE` clocks, and the duty value moves only on that pulse. A two-state direction machine decides whether each step adds or subtracts. The machine has the states `SWEEP_RISE` and `SWEEP_FALL`, and it watches the registered duty value on every clock. It uses two transitions. `RISE_TO_FALL` fires when the duty value has reached the top, and `FALL_TO_RISE` fires when the duty value has reached zero. Every other combination of state and value keeps the current state.

A free-running PWM counter runs from 0 to 99. It is compared against the duty value to drive a PWM pin, so the pin is high for exactly `duty` clocks out of every 100. The direction machine holds a PWM enable high in both states. Because steps are at least two clocks apart, the direction machine always turns around before the next step can push the value out of range. A typical use is driving an LED or a test load with a slowly breathing PWM waveform.

Top module: `tri_sweep_gen`

## Requirements
- R1: On a clock edge where the step pulse is high, the duty value grows by exactly 2 while the direction output is 1 (rising), and it shrinks by exactly 2 while the direction output is 0 (falling).
- R2: On a clock edge where the step pulse is low, the duty value keeps its value.
- R3: The duty value stays even and within 0 to 100 at all times. Starting from reset, successive steps give 0, 2, ..., 100, 98, ..., 0, 2, and the pattern repeats.
- R4: When the duty value is 100 and the direction is rising, the direction output becomes 0 on the next clock.
- R5: When the duty value is 0 and the direction is falling, the direction output becomes 1 on the next clock.
- R6: While reset is asserted and after it is released, the duty value is 0, the direction output is 1, the step pulse is 0 and the PWM pin is 0, until the first step occurs.
- R7: The step pulse is high for exactly one clock. It is high for the first time `PRESCALE` clocks after reset is released, and again every `PRESCALE` clocks after that.
- R8: The PWM enable output is 1 in both direction states.
- R9: Over any 100 consecutive clocks in which the duty value does not change, the PWM pin is high for exactly `duty` clocks. This means it never goes high at duty 0 and is always high at duty 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst | input | 1 | Asynchronous reset, active high |
| duty_o | output | 7 | Current duty value, 0 to 100 |
| dir_up_o | output | 1 | Direction: 1 rising, 0 falling |
| pwm_en_o | output | 1 | PWM enable, high in both direction states |
| pwm_o | output | 1 | PWM output |
| tick_o | output | 1 | One-clock step pulse from the prescaler |

## Verification
The assertions check, on every clock, that each step adds or subtracts 2 according to the direction. They also check that the value holds between steps, that it stays even and inside 0 to 100, that both turn-arounds happen on the next clock, that the PWM enable stays high, that the step pulse lasts one clock, and that the PWM pin is forced low at duty 0 and forced high at duty 100. Some properties need a long window and can only be shown by the bench's directed scenarios. These are the exact spacing of the step pulses, the full value sequence over two complete sweeps ending on 0 then 2, and the PWM high-time counted over 100-clock windows at several duty values.

// File: rtl/tri_sweep_pkg.sv
package tri_sweep_pkg;

    // Direction of the sweep
    typedef enum logic [0:0] {
        SWEEP_RISE = 1'b0,
        SWEEP_FALL = 1'b1
    } sweep_dir_e;

    // Width needed to hold values 0..max_val
    function automatic int unsigned width_for(input int unsigned max_val);
        int unsigned w;
        w = 1;
        while ((2 ** w) <= max_val) begin
            w = w + 1;
        end
        return w;
    endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int unsigned DIV = 500
) (
    input  logic clk,
    input  logic arst,
    output logic tick_o
);
    localparam int unsigned CW = tri_sweep_pkg::width_for(DIV - 1);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] div_cnt;
    logic          tick_q;

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            div_cnt <= '0;
            tick_q  <= 1'b0;
        end else begin
            tick_q <= (div_cnt == LAST);
            if (div_cnt == LAST) begin
                div_cnt <= '0;
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end

    assign tick_o = tick_q;

endmodule

// File: rtl/sweep_dir_fsm.sv
module sweep_dir_fsm
    import tri_sweep_pkg::*;
#(
    parameter int unsigned DW  = 7,
    parameter int unsigned TOP = 100
) (
    input  logic          clk,
    input  logic          arst,
    input  logic [DW-1:0] duty_i,
    output logic          rising_o,
    output logic          pwm_en_o
);
    localparam logic [DW-1:0] TOP_V = DW'(TOP);

    sweep_dir_e state_q;
    sweep_dir_e state_d;

    // State register
    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            state_q <= SWEEP_RISE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: RISE_TO_FALL at the top, FALL_TO_RISE at zero
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SWEEP_RISE: begin
                if (duty_i >= TOP_V) begin
                    state_d = SWEEP_FALL;
                end
            end
            SWEEP_FALL: begin
                if (duty_i == '0) begin
                    state_d = SWEEP_RISE;
                end
            end
            default: state_d = SWEEP_RISE;
        endcase
    end

    // Outputs per state
    always_comb begin
        rising_o = 1'b1;
        pwm_en_o = 1'b1;
        unique case (state_q)
            SWEEP_RISE: begin
                rising_o = 1'b1;
                pwm_en_o = 1'b1;
            end
            SWEEP_FALL: begin
                rising_o = 1'b0;
                pwm_en_o = 1'b1;
            end
            default: begin
                rising_o = 1'b1;
                pwm_en_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/duty_stepper.sv
module duty_stepper #(
    parameter int unsigned DW   = 7,
    parameter int unsigned STEP = 2
) (
    input  logic          clk,
    input  logic          arst,
    input  logic          tick_i,
    input  logic          rising_i,
    output logic [DW-1:0] duty_o
);
    localparam logic [DW-1:0] STEP_V = DW'(STEP);

    logic [DW-1:0] duty_q;

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            duty_q <= '0;
        end else if (tick_i) begin
            if (rising_i) begin
                duty_q <= duty_q + STEP_V;
            end else begin
                duty_q <= duty_q - STEP_V;
            end
        end
    end

    assign duty_o = duty_q;

endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
    parameter int unsigned DW     = 7,
    parameter int unsigned PERIOD = 100
) (
    input  logic          clk,
    input  logic          arst,
    input  logic          en_i,
    input  logic [DW-1:0] duty_i,
    output logic          pwm_o
);
    localparam int unsigned CW   = tri_sweep_pkg::width_for(PERIOD - 1);
    localparam int unsigned XW   = (CW > DW) ? CW : DW;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] phase_q;

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign pwm_o = en_i && (XW'(phase_q) < XW'(duty_i));

endmodule

// File: rtl/tri_sweep_gen.sv
module tri_sweep_gen #(
    parameter int unsigned PRESCALE   = 500,
    parameter int unsigned DUTY_TOP   = 100,
    parameter int unsigned DUTY_STEP  = 2,
    parameter int unsigned PWM_PERIOD = 100,
    parameter int unsigned DW         = tri_sweep_pkg::width_for(DUTY_TOP)
) (
    input  logic          clk,
    input  logic          arst,
    output logic [DW-1:0] duty_o,
    output logic          dir_up_o,
    output logic          pwm_en_o,
    output logic          pwm_o,
    output logic          tick_o
);
    logic          tick;
    logic          rising;
    logic          pwm_en;
    logic [DW-1:0] duty;

    tick_prescaler #(.DIV(PRESCALE)) u_prescaler (
        .clk    (clk),
        .arst   (arst),
        .tick_o (tick)
    );

    sweep_dir_fsm #(.DW(DW), .TOP(DUTY_TOP)) u_dir (
        .clk      (clk),
        .arst     (arst),
        .duty_i   (duty),
        .rising_o (rising),
        .pwm_en_o (pwm_en)
    );

    duty_stepper #(.DW(DW), .STEP(DUTY_STEP)) u_step (
        .clk      (clk),
        .arst     (arst),
        .tick_i   (tick),
        .rising_i (rising),
        .duty_o   (duty)
    );

    pwm_compare #(.DW(DW), .PERIOD(PWM_PERIOD)) u_pwm (
        .clk    (clk),
        .arst   (arst),
        .en_i   (pwm_en),
        .duty_i (duty),
        .pwm_o  (pwm_o)
    );

    assign duty_o   = duty;
    assign dir_up_o = rising;
    assign pwm_en_o = pwm_en;
    assign tick_o   = tick;

endmodule

// File: rtl/tri_sweep_chk.sv
module tri_sweep_chk #(
    parameter int unsigned DW   = 7,
    parameter int unsigned TOP  = 100,
    parameter int unsigned STEP = 2
) (
    input logic          clk,
    input logic          arst,
    input logic [DW-1:0] duty,
    input logic          dir_up,
    input logic          pwm_en,
    input logic          pwm,
    input logic          tick
);
    // R1: step up / step down by STEP on a tick
    a_r1_step_up: assert property (@(posedge clk) disable iff (arst)
        (tick && dir_up) |=> (int'(duty) == int'($past(duty)) + int'(STEP)));
    a_r1_step_down: assert property (@(posedge clk) disable iff (arst)
        (tick && !dir_up) |=> (int'(duty) == int'($past(duty)) - int'(STEP)));

    // R2: no movement without a tick
    a_r2_hold: assert property (@(posedge clk) disable iff (arst)
        !tick |=> $stable(duty));

    // R3: value stays even and in range
    a_r3_in_range: assert property (@(posedge clk) disable iff (arst)
        (int'(duty) <= int'(TOP)) && (duty[0] == 1'b0));

    // R4: turn down at the top
    a_r4_turn_down: assert property (@(posedge clk) disable iff (arst)
        (dir_up && (int'(duty) == int'(TOP))) |=> !dir_up);

    // R5: turn up at zero
    a_r5_turn_up: assert property (@(posedge clk) disable iff (arst)
        (!dir_up && (duty == '0)) |=> dir_up);

    // R7: step pulse lasts one clock
    a_r7_single_tick: assert property (@(posedge clk) disable iff (arst)
        tick |=> !tick);

    // R8: PWM enable high in both states
    a_r8_pwm_enabled: assert property (@(posedge clk) disable iff (arst)
        pwm_en);

    // R9: PWM forced at the extremes
    a_r9_pwm_off_at_zero: assert property (@(posedge clk) disable iff (arst)
        (duty == '0) |-> !pwm);
    a_r9_pwm_on_at_top: assert property (@(posedge clk) disable iff (arst)
        (int'(duty) == int'(TOP)) |-> pwm);

endmodule

bind tri_sweep_gen tri_sweep_chk #(.DW(DW), .TOP(DUTY_TOP), .STEP(DUTY_STEP)) u_sweep_chk (
    .clk    (clk),
    .arst   (arst),
    .duty   (duty_o),
    .dir_up (dir_up_o),
    .pwm_en (pwm_en_o),
    .pwm    (pwm_o),
    .tick   (tick_o)
);

// File: tb/test_tri_sweep_gen.sv
module test_tri_sweep_gen;
    localparam int CLK_PERIOD = 10;
    localparam int TB_DIV     = 150;
    localparam int WD_LIMIT   = 100000;

    logic       clk;
    logic       arst;
    logic [6:0] duty_o;
    logic       dir_up_o;
    logic       pwm_en_o;
    logic       pwm_o;
    logic       tick_o;

    int checks;
    int errors;
    int since_tick;
    bit done;

    tri_sweep_gen #(.PRESCALE(TB_DIV)) i_tri_sweep_gen (
        .clk      (clk),
        .arst     (arst),
        .duty_o   (duty_o),
        .dir_up_o (dir_up_o),
        .pwm_en_o (pwm_en_o),
        .pwm_o    (pwm_o),
        .tick_o   (tick_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        since_tick++;
    endtask

    task automatic pwm_window(input string req, input int exp_high);
        int high = 0;
        for (int k = 0; k < 100; k++) begin
            step();
            if (pwm_o) high++;
        end
        check(req, high, exp_high);
    endtask

    // R6 reset state, R9 at duty 0
    task automatic t_reset();
        arst = 1'b1;
        repeat (3) @(negedge clk);
        check("R6 duty in reset", int'(duty_o), 0);
        check("R6 dir in reset", int'(dir_up_o), 1);
        check("R6 tick in reset", int'(tick_o), 0);
        check("R6 pwm in reset", int'(pwm_o), 0);
        arst = 1'b0;
        since_tick = 0;
        step();
        check("R6 duty after release", int'(duty_o), 0);
        check("R6 dir after release", int'(dir_up_o), 1);
        check("R8 pwm_en rising", int'(pwm_en_o), 1);
        pwm_window("R9 pwm at duty 0", 0);
        check("R6 duty still 0 before first step", int'(duty_o), 0);
    endtask

    // R1..R5, R7..R9 across two full sweeps plus one step
    task automatic t_sweep();
        int exp_duty = 0;
        bit exp_up   = 1'b1;
        for (int i = 0; i < 201; i++) begin
            while (!tick_o) step();
            check(i == 0 ? "R7 first tick spacing" : "R7 tick spacing", since_tick, TB_DIV);
            check("R2 duty held between steps", int'(duty_o), exp_duty);
            since_tick = 0;
            exp_duty = exp_up ? exp_duty + 2 : exp_duty - 2;
            step();
            check("R7 tick one clock wide", int'(tick_o), 0);
            check(exp_up ? "R1 step up" : "R1 step down", int'(duty_o), exp_duty);
            check("R3 duty in range", int'(duty_o <= 7'd100), 1);
            if (exp_duty == 100) exp_up = 1'b0;
            else if (exp_duty == 0) exp_up = 1'b1;
            step();
            if (exp_duty == 100)
                check("R4 turn down at top", int'(dir_up_o), 0);
            else if (exp_duty == 0)
                check("R5 turn up at zero", int'(dir_up_o), 1);
            else
                check("R1 direction kept", int'(dir_up_o), int'(exp_up));
            check("R8 pwm_en", int'(pwm_en_o), 1);
            if (exp_duty == 2 || exp_duty == 50 || exp_duty == 100 ||
                exp_duty == 0 || exp_duty == 98) begin
                pwm_window("R9 pwm high count", exp_duty);
            end
        end
        check("R3 final value after two sweeps", exp_duty, 2);
        check("R3 final duty port", int'(duty_o), 2);
    endtask

    initial begin
        checks = 0;
        errors = 0;
        done = 1'b0;
        since_tick = 0;
        arst = 1'b1;
        t_reset();
        t_sweep();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", WD_LIMIT, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule